// File: doc/BRIEF.md
# Three-Phase Complementary Dead-Band PWM

This block drives the gates of a three-leg inverter. Each leg has a high-side switch and a low-side switch, which gives six gate outputs. A symmetric up/down counter sets the switching period. Each leg compares that counter with its own duty value. The two switches of a leg are driven as complements, and a programmable gap of idle clock cycles separates every change of state, so one switch is always fully off before the other turns on.

The host writes the three duty values at any time. They go into a holding bank and move into the working bank only when the counter sits at zero. A duty update therefore takes effect at the start of a period, never partway through one.

Two protections share one sticky fault flag:
- an external over-current trip input;
- a per-switch check that reports a switch driven on while its sensed voltage is not low, once a settling window after turn-on has passed.

While the flag is set, all six gates are held off. The flag is released only after the host asks for it to be cleared and the counter next returns to zero.

Top module: `pwm3_gate_top`

## Requirements
- R1: The high-side and low-side outputs of one leg are never both 1 in the same cycle.
- R2: After a leg's raw drive level changes, both of its outputs stay 0 for exactly `dead_cyc` cycles before the newly selected output turns on.
- R3: While enabled, the counter steps by one per clock: up from 0 to `peak`, then down to 0, giving a period of 2·`peak` cycles. A leg's raw high-side level is 1 while the counter is below that leg's working duty value. A duty value of 0 keeps the high side always off. A value above `peak` keeps it always on. A duty value C gives a high-side pulse of 2C−1−`dead_cyc` cycles, centred on the counter's zero point.
- R4: A pulse on `cmp_wr` loads `cmp_data` into the holding bank, with leg k in bits [k·CW +: CW]. The holding bank is copied into the working bank on a clock edge at which the counter is 0. `upd_pending` rises after a write and is cleared by that copy.
- R5: A raw pulse no longer than `dead_cyc` cycles never appears on the output.
- R6: `kill` high forces all six outputs to 0 in the same cycle, without waiting for a clock edge. It also sets `fault` at the next edge.
- R7: Switch i trips the fault when it is driven on, has been on for at least `blank_cyc` cycles, and `sense_low[i]` is 0. Bit k of `sense_low` belongs to the high side of leg k, and bit NLEG+k belongs to the low side of leg k.
- R8: During the first `blank_cyc` cycles after a switch turns on, its sense input is ignored.
- R9: While `fault` is 1, all outputs are 0. A pulse on `fault_clr` arms a release. `fault` then clears on the next edge at which the counter is 0, provided no fault source is active at that edge.
- R10: After reset, and whenever `enable` is 0, all outputs are 0 and the counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the counter; when 0, all gates are off |
| peak | input | CW | Top value of the triangle counter |
| cmp_wr | input | 1 | Write strobe for the holding duty bank |
| cmp_data | input | NLEG·CW | Duty values, one CW-bit field per leg |
| dead_cyc | input | DW | Gap length in cycles |
| blank_cyc | input | BW | Settling window after a switch turns on |
| kill | input | 1 | External over-current trip |
| sense_low | input | 2·NLEG | Per-switch sense: 1 = switch voltage low |
| fault_clr | input | 1 | Arms fault release at the next counter zero |
| gate_hi | output | NLEG | High-side gate drives |
| gate_lo | output | NLEG | Low-side gate drives |
| fault | output | 1 | Sticky fault flag |
| upd_pending | output | 1 | Holding bank not yet copied to the working bank |

## Verification
The bench runs the three legs with three different duty values at once:
- a narrow value whose pulse is shorter than the gap, which separates correct suppression from a glitch;
- a mid value, which fixes pulse width, period and gap length;
- a value above the peak, which gives a steady on state.

A new set of duty values (0, mid and high) is then written partway through a period. The point at which the outputs change shows whether the update waited for the counter's zero point.

Faults are raised in two ways: by the trip input, and by a sense input held off on a switch that is on. The sense fault is raised once with a settling window longer than the pulse, where nothing may trip, and once with a short window, where it must trip. After each fault, the bench checks that the release waits for the counter's zero point.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int unsigned LEGS      = 3;
    localparam int unsigned CNT_W_DEF = 12;
    localparam int unsigned DT_W_DEF  = 8;
    localparam int unsigned BLK_W_DEF = 8;

    // Direction of the triangle counter
    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    // Gate pair of one leg
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drive_t;

    // Fault sources seen in one cycle
    typedef struct packed {
        logic trip_in;
        logic desat;
    } flt_src_t;

    function automatic logic any_src(flt_src_t s);
        return s.trip_in | s.desat;
    endfunction
endpackage

// File: rtl/pwm3_tri_cnt.sv
module pwm3_tri_cnt
    import pwm3_pkg::*;
#(
    parameter int unsigned CW   = CNT_W_DEF,
    parameter int unsigned NLEG = LEGS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [CW-1:0]        peak,
    input  logic                 wr,
    input  logic [NLEG*CW-1:0]   wdata,
    output logic [CW-1:0]        cnt,
    output logic [NLEG*CW-1:0]   act,
    output logic                 valley,
    output logic                 pending
);
    localparam logic [CW-1:0] ONE = CW'(1);

    slope_e              slope_q;
    logic [CW-1:0]       cnt_q;
    logic [NLEG*CW-1:0]  shadow_q;
    logic [NLEG*CW-1:0]  act_q;
    logic                pend_q;

    assign valley  = (cnt_q == '0);
    assign cnt     = cnt_q;
    assign act     = act_q;
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q   <= '0;
            slope_q <= SLOPE_UP;
        end else if (slope_q == SLOPE_UP) begin
            cnt_q <= cnt_q + ONE;
            if ((cnt_q + ONE) == peak) slope_q <= SLOPE_DOWN;
        end else begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) slope_q <= SLOPE_UP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act_q    <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (valley) begin
                act_q  <= shadow_q;
                pend_q <= wr;
            end else if (wr) begin
                pend_q <= 1'b1;
            end
            if (wr) shadow_q <= wdata;
        end
    end

    // R4
    act_at_valley_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q != $past(act_q)) |-> $past(valley));

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        enable |=> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt_q == '0));
endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband
    import pwm3_pkg::*;
#(
    parameter int unsigned CW = CNT_W_DEF,
    parameter int unsigned DW = DT_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [DW-1:0] dead,
    input  logic          allow,
    output leg_drive_t    drv
);
    logic          raw_d;
    logic          raw_q;
    logic [DW-1:0] run_q;
    logic          settled;

    assign raw_d = enable && (cnt < cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            run_q <= '0;
        end else begin
            raw_q <= raw_d;
            if (raw_d != raw_q)   run_q <= '0;
            else if (run_q != '1) run_q <= run_q + DW'(1);
        end
    end

    assign settled = (run_q >= dead);
    assign drv.hi  = allow && raw_q && settled;
    assign drv.lo  = allow && !raw_q && settled;

    // R2
    lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(drv.lo) && dead != '0) |-> !drv.hi);

    // R2
    hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(drv.hi) && dead != '0) |-> !drv.lo);
endmodule

// File: rtl/pwm3_desat.sv
module pwm3_desat
    import pwm3_pkg::*;
#(
    parameter int unsigned BW = BLK_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gate,
    input  logic          sense_low,
    input  logic [BW-1:0] blank,
    output logic          trip
);
    logic [BW-1:0] on_q;

    always_ff @(posedge clk) begin
        if (rst || !gate)    on_q <= '0;
        else if (on_q != '1) on_q <= on_q + BW'(1);
    end

    assign trip = gate && !sense_low && (on_q >= blank);

    // R8
    blank_window_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && !$past(gate) && blank != '0) |-> !trip);
endmodule

// File: rtl/pwm3_gate_top.sv
module pwm3_gate_top
    import pwm3_pkg::*;
#(
    parameter int unsigned NLEG = LEGS,
    parameter int unsigned CW   = CNT_W_DEF,
    parameter int unsigned DW   = DT_W_DEF,
    parameter int unsigned BW   = BLK_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [CW-1:0]        peak,
    input  logic                 cmp_wr,
    input  logic [NLEG*CW-1:0]   cmp_data,
    input  logic [DW-1:0]        dead_cyc,
    input  logic [BW-1:0]        blank_cyc,
    input  logic                 kill,
    input  logic [2*NLEG-1:0]    sense_low,
    input  logic                 fault_clr,
    output logic [NLEG-1:0]      gate_hi,
    output logic [NLEG-1:0]      gate_lo,
    output logic                 fault,
    output logic                 upd_pending
);
    localparam int unsigned NSW = 2 * NLEG;

    logic [CW-1:0]      cnt;
    logic [NLEG*CW-1:0] act;
    logic               valley;
    logic               fault_q;
    logic               arm_q;
    logic               allow;
    logic [NSW-1:0]     gate_all;
    logic [NSW-1:0]     trip;
    flt_src_t           src;

    pwm3_tri_cnt #(.CW(CW), .NLEG(NLEG)) cnt_i (
        .clk(clk), .rst(rst), .enable(enable), .peak(peak),
        .wr(cmp_wr), .wdata(cmp_data),
        .cnt(cnt), .act(act), .valley(valley), .pending(upd_pending)
    );

    assign allow = enable && !kill && !fault_q;

    for (genvar k = 0; k < NLEG; k++) begin : g_leg
        leg_drive_t drv;
        pwm3_deadband #(.CW(CW), .DW(DW)) db_i (
            .clk(clk), .rst(rst), .enable(enable), .cnt(cnt),
            .cmp(act[k*CW +: CW]), .dead(dead_cyc), .allow(allow), .drv(drv)
        );
        assign gate_hi[k] = drv.hi;
        assign gate_lo[k] = drv.lo;

        // R1
        leg_overlap_chk: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[k] && gate_lo[k]));
    end

    assign gate_all = {gate_lo, gate_hi};

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        pwm3_desat #(.BW(BW)) ds_i (
            .clk(clk), .rst(rst), .gate(gate_all[i]),
            .sense_low(sense_low[i]), .blank(blank_cyc), .trip(trip[i])
        );
    end

    assign src.trip_in = kill;
    assign src.desat   = |trip;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            if (any_src(src))          fault_q <= 1'b1;
            else if (arm_q && valley)  fault_q <= 1'b0;
            if (fault_clr)                             arm_q <= 1'b1;
            else if (arm_q && valley && !any_src(src)) arm_q <= 1'b0;
        end
    end

    assign fault = fault_q;

    // R6
    kill_off_chk: assert property (@(posedge clk) disable iff (rst)
        kill |-> (gate_hi == '0 && gate_lo == '0));

    // R6
    kill_latch_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> fault);

    // R7
    desat_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|trip) |=> fault);

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (gate_hi == '0 && gate_lo == '0));

    // R9
    fault_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> $past(valley));

    // R10
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (gate_hi == '0 && gate_lo == '0));

    // R4
    pending_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(valley) && !$past(cmp_wr)) |-> !upd_pending);
endmodule

// File: tb/pwm3_gate_top_tb_top.sv
`timescale 1ns/1ps
module pwm3_gate_top_tb_top;
    localparam int NL = 3;
    localparam int CW = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en = 1'b0;
    logic [CW-1:0]   peak = 12'd20;
    logic            wr = 1'b0;
    logic [CW-1:0]   wd [NL];
    logic [7:0]      dead = 8'd3;
    logic [7:0]      blank = 8'd2;
    logic            kill = 1'b0;
    logic            clr = 1'b0;
    logic [5:0]      inj = 6'd0;
    logic [NL*CW-1:0] cmp_data;
    logic [5:0]      sense;
    logic [NL-1:0]   gate_hi, gate_lo;
    logic            fault, upd_pending;

    int n_chk = 0;
    int n_fail = 0;
    int overlap = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign cmp_data = {wd[2], wd[1], wd[0]};
    assign sense    = {gate_lo, gate_hi} & ~inj;

    pwm3_gate_top dut_i (
        .clk(clk), .rst(rst), .enable(en), .peak(peak),
        .cmp_wr(wr), .cmp_data(cmp_data), .dead_cyc(dead), .blank_cyc(blank),
        .kill(kill), .sense_low(sense), .fault_clr(clr),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault), .upd_pending(upd_pending)
    );

    // ---------------- reference model ----------------
    int m_cnt = 0;
    bit m_down = 0;
    int m_sh [NL] = '{0, 0, 0};
    int m_act [NL] = '{0, 0, 0};
    bit m_pend = 0;
    bit m_raw [NL] = '{0, 0, 0};
    int m_run [NL] = '{0, 0, 0};
    bit m_fault = 0;
    bit m_arm = 0;
    int m_on [6] = '{0, 0, 0, 0, 0, 0};

    function automatic logic [5:0] m_gates();
        logic [5:0] g;
        bit ok;
        ok = en && !kill && !m_fault;
        for (int k = 0; k < NL; k++) begin
            g[k]      = ok && m_raw[k] && (m_run[k] >= int'(dead));
            g[NL + k] = ok && !m_raw[k] && (m_run[k] >= int'(dead));
        end
        return g;
    endfunction

    always @(posedge clk) begin : model
        logic [5:0] g;
        bit trip;
        bit vall;
        bit nr;
        if (rst) begin
            m_cnt = 0; m_down = 0; m_pend = 0; m_fault = 0; m_arm = 0;
            for (int k = 0; k < NL; k++) begin
                m_sh[k] = 0; m_act[k] = 0; m_raw[k] = 0; m_run[k] = 0;
            end
            for (int i = 0; i < 6; i++) m_on[i] = 0;
        end else begin
            g = m_gates();
            trip = 0;
            for (int i = 0; i < 6; i++) begin
                if (g[i] && inj[i] && m_on[i] >= int'(blank)) trip = 1;
                m_on[i] = g[i] ? ((m_on[i] < 255) ? m_on[i] + 1 : 255) : 0;
            end
            vall = (m_cnt == 0);
            for (int k = 0; k < NL; k++) begin
                nr = en && (m_cnt < m_act[k]);
                if (nr != m_raw[k])      m_run[k] = 0;
                else if (m_run[k] < 255) m_run[k] = m_run[k] + 1;
                m_raw[k] = nr;
            end
            if (kill || trip)           m_fault = 0 == 0;
            else if (m_arm && vall)     m_fault = 0;
            if (clr)                                m_arm = 1;
            else if (m_arm && vall && !(kill || trip)) m_arm = 0;
            if (vall) begin
                for (int k = 0; k < NL; k++) m_act[k] = m_sh[k];
                m_pend = wr;
            end else if (wr) begin
                m_pend = 1;
            end
            if (wr) for (int k = 0; k < NL; k++) m_sh[k] = int'(wd[k]);
            if (!en) begin
                m_cnt = 0; m_down = 0;
            end else if (!m_down) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == int'(peak)) m_down = 1;
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_down = 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [5:0] g;
        logic       f;
        logic       p;
    } exp_t;
    exp_t sb_q [$];
    event mon_ev;

    always @(mon_ev) begin : monitor
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if ({gate_lo, gate_hi} !== e.g) begin
            n_fail++;
            $display("FAIL R2,R3 gates at %0t: got %b expected %b", $time, {gate_lo, gate_hi}, e.g);
        end
        n_chk++;
        if (fault !== e.f) begin
            n_fail++;
            $display("FAIL R9 fault at %0t: got %b expected %b", $time, fault, e.f);
        end
        n_chk++;
        if (upd_pending !== e.p) begin
            n_fail++;
            $display("FAIL R4 pending at %0t: got %b expected %b", $time, upd_pending, e.p);
        end
        for (int k = 0; k < NL; k++) if (gate_hi[k] && gate_lo[k]) overlap++;
    end

    task automatic cyc();
        exp_t e;
        @(negedge clk);
        e.g = m_gates();
        e.f = m_fault;
        e.p = m_pend;
        sb_q.push_back(e);
        -> mon_ev;
        #1;
    endtask

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int fall_t, gap, hw, width, rise1, per;
        bit hi0_seen, p1, got;
        wd[0] = '0; wd[1] = '0; wd[2] = '0;
        run(5);
        rst = 1'b0;
        cyc();
        // R10: reset state
        chk({gate_lo, gate_hi} == 6'd0, "R10 gates after reset", {gate_lo, gate_hi}, 0);
        chk(fault == 1'b0, "R9 fault after reset", fault, 0);
        chk(upd_pending == 1'b0, "R4 pending after reset", upd_pending, 0);

        // R4: load duty values while idle
        wd[0] = 12'd2; wd[1] = 12'd10; wd[2] = 12'd25; wr = 1'b1;
        cyc();
        wr = 1'b0;
        chk(upd_pending == 1'b1, "R4 pending after write", upd_pending, 1);
        cyc();
        chk(upd_pending == 1'b0, "R4 pending after copy", upd_pending, 0);
        run(3);
        chk({gate_lo, gate_hi} == 6'd0, "R10 gates while disabled", {gate_lo, gate_hi}, 0);

        // R3, R2, R5: steady run
        en = 1'b1;
        fall_t = -1; gap = -1; hw = 0; width = -1; rise1 = -1; per = -1;
        hi0_seen = 0; p1 = 0;
        for (int t = 0; t < 120; t++) begin
            cyc();
            if (gate_hi[0]) hi0_seen = 1;
            if (gate_hi[1] && !p1) begin
                if (rise1 >= 0) per = t - rise1;
                rise1 = t;
                hw = 1;
            end else if (gate_hi[1]) begin
                hw++;
            end
            if (!gate_hi[1] && p1) begin
                width = hw;
                fall_t = t;
            end
            if (gate_lo[1] && fall_t >= 0 && gap < 0) gap = t - fall_t;
            p1 = gate_hi[1];
        end
        chk(!hi0_seen, "R5 short pulse suppressed on leg0", hi0_seen, 0);
        chk(gap == int'(dead), "R2 gap high-to-low leg1", gap, int'(dead));
        chk(width == 16, "R3 pulse width leg1", width, 16);
        chk(per == 40, "R3 period leg1", per, 40);
        chk(gate_hi[2] == 1'b1 && gate_lo[2] == 1'b0, "R3 duty above peak leg2", gate_hi[2], 1);

        // R4: mid-period update
        got = 0; p1 = gate_hi[1];
        for (int t = 0; t < 60 && !got; t++) begin
            cyc();
            if (gate_hi[1] && !p1) got = 1;
            p1 = gate_hi[1];
        end
        wd[0] = 12'd0; wd[1] = 12'd7; wd[2] = 12'd15; wr = 1'b1;
        cyc();
        wr = 1'b0;
        chk(upd_pending == 1'b1, "R4 pending mid-period", upd_pending, 1);
        run(40);
        chk(upd_pending == 1'b0, "R4 pending cleared at zero point", upd_pending, 0);
        hi0_seen = 0;
        for (int t = 0; t < 80; t++) begin
            cyc();
            if (gate_hi[0]) hi0_seen = 1;
        end
        chk(!hi0_seen && gate_lo[0], "R3 zero duty keeps leg0 low side on", gate_lo[0], 1);

        // R6, R9: trip input
        kill = 1'b1;
        #1;
        chk({gate_lo, gate_hi} == 6'd0, "R6 outputs off at once", {gate_lo, gate_hi}, 0);
        cyc();
        kill = 1'b0;
        cyc();
        chk(fault == 1'b1, "R6 fault latched", fault, 1);
        chk({gate_lo, gate_hi} == 6'd0, "R9 outputs held off", {gate_lo, gate_hi}, 0);
        run(7);
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        chk(fault == 1'b1, "R9 fault held until zero point", fault, 1);
        got = 0;
        for (int t = 0; t < 45 && !got; t++) begin
            cyc();
            if (!fault) got = 1;
        end
        chk(got, "R9 fault released", fault, 0);

        // R8: settling window longer than the pulse
        run(45);
        blank = 8'd200;
        inj = 6'b000100;
        run(80);
        chk(fault == 1'b0, "R8 sense ignored inside window", fault, 0);

        // R7: short window trips
        blank = 8'd2;
        run(60);
        chk(fault == 1'b1, "R7 sense fault latched", fault, 1);
        chk({gate_lo, gate_hi} == 6'd0, "R9 outputs off after sense fault", {gate_lo, gate_hi}, 0);
        inj = 6'd0;
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        run(45);
        chk(fault == 1'b0, "R9 release after sense fault", fault, 0);

        // R10: disable
        en = 1'b0;
        cyc();
        chk({gate_lo, gate_hi} == 6'd0, "R10 gates off when disabled", {gate_lo, gate_hi}, 0);
        run(3);

        // R1: no overlap seen in any cycle
        chk(overlap == 0, "R1 leg overlap count", overlap, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule